// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Power-Up Initializer

This block keeps a fast-page-mode DRAM refreshed without any help from the host access path. After reset it waits out a power-up pause and then runs a fixed number of refresh cycles. Only after that does it declare the memory usable. From then on a distributed interval timer records one owed refresh per interval. The block asks a shared-bus arbiter for the strobe lines and, once granted, drives each refresh itself as a CAS-before-RAS cycle. The memory's own internal row counter selects the row, so the block drives no address.

Refreshes that the arbiter postpones are counted in a small saturating counter and issued as one burst when the bus comes back. When that counter is full the block raises an urgency flag so the arbiter can put refresh ahead of host traffic. A low-power request puts the memory into self refresh, which keeps both strobes low. The block brackets that state with one refresh just before entry and one just after exit. It enforces a minimum strobe-low time in self refresh and a longer precharge on exit.

All timing values are parameters counted in clock cycles. The defaults assume a 5 ns clock: 40000 cycles of pause, a 3100-cycle interval, a 20000-cycle minimum self-refresh hold and a 22-cycle exit precharge. Strobes are active low. No data flows through the block, so all of its pins are plain level control and status signals.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, ras_n, cas_n, we_n and oe_n are high, and ref_req, ref_urgent, bus_own, init_done and sr_active are low.
- R2: For the first INIT_CYC cycles after reset release, ref_req stays low and neither strobe leaves its high level, whatever ref_grant does.
- R3: After the pause, exactly INIT_REFS refresh cycles are issued, and init_done then rises and stays high.
- R4: Every refresh is CAS-before-RAS. cas_n goes low exactly T_CSR cycles before ras_n falls, ras_n then stays low for T_RAS cycles with cas_n low throughout, and both strobes stay high for at least T_RP cycles before the next cycle starts.
- R5: we_n is high and oe_n is high at every falling edge of ras_n, so a refresh can never be taken as a write or a test-mode entry.
- R6: Once init_done is high and ref_grant is held high, successive refresh cycles begin exactly REF_INTERVAL cycles apart.
- R7: While ref_grant is low, owed refreshes accumulate up to PEND_MAX and further ones are dropped. When the grant returns they are issued back to back with a spacing of T_CSR+T_RAS+T_RP+1 cycles, and ref_req falls after the last one.
- R8: ref_urgent is high exactly when the owed count equals PEND_MAX in normal operation.
- R9: A refresh cycle starts only on an edge where ref_grant is high, and bus_own is high from the first strobe movement until the precharge ends. ref_req is high whenever work is owed.
- R10: A self-refresh request is served by one complete refresh cycle followed, after a normal precharge gap, by both strobes going low and held. sr_active is high while they are held, and ref_req and bus_own stay high.
- R11: ras_n stays low in self refresh for at least T_RASS cycles even if sr_exit_req is already high. If the exit is requested early it stays low for exactly T_RASS cycles.
- R12: On exit, ras_n stays high for T_RPS+1+T_CSR cycles before one more refresh cycle. Normal operation then resumes with the owed count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_grant | input | 1 | Arbiter gives the strobe bus to this block |
| sr_enter_req | input | 1 | Level request to place the memory in self refresh |
| sr_exit_req | input | 1 | Level request to leave self refresh |
| ref_req | output | 1 | Refresh work is owed; asks the arbiter for the bus |
| ref_urgent | output | 1 | Owed count is at its limit; refresh should win arbitration |
| bus_own | output | 1 | A strobe sequence is in progress on the bus |
| init_done | output | 1 | Power-up sequence finished; memory may be accessed |
| sr_active | output | 1 | Memory is being held in self refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| oe_n | output | 1 | Output enable, held high |

## Verification
The main function is exercised with three grant patterns. A grant held high throughout shows the exact refresh period. A grant withheld for one, two, four, five and seven intervals gives bursts of 1, 2, 4, 4 and 4, which separates plain accumulation from saturation and shows urgency rising only at the limit. A withheld grant combined with a self-refresh request checks that owed work is not replayed and is cleared. Strobe pulse widths and gaps are measured at every edge of ras_n. A wrong CAS lead, a short row pulse or a short post-exit precharge therefore shows up as a cycle-count mismatch rather than passing unseen.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_INIT,
    ST_RUN,
    ST_SR_PRE,
    ST_SR_ENTER,
    ST_SR_IN,
    ST_SR_POST
  } sched_state_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_RASLO,
    PH_SRHOLD,
    PH_PRE
  } strobe_phase_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/drs_interval_timer.sv
module drs_interval_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic tick
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (en)     cnt <= tick ? '0 : cnt + 1'b1;
  end

  // The count never runs past the terminal value
  AST_TMR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R6

endmodule

// File: rtl/drs_pending_ctr.sv
module drs_pending_ctr #(
  parameter  int MAX = 4,
  localparam int CW  = $clog2(MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic clr,
  output logic full,
  output logic empty
);
  localparam logic [CW-1:0] TOP = CW'(MAX);

  logic [CW-1:0] count;

  assign full  = (count == TOP);
  assign empty = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   if (!full)  count <= count + 1'b1;
        2'b01:   if (!empty) count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= TOP); // R7

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && inc && !dec && !clr) |=> full); // R7

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !empty); // R7

endmodule

// File: rtl/drs_cbr_seq.sv
module drs_cbr_seq
  import drs_pkg::*;
#(
  parameter int T_CSR  = 2,
  parameter int T_RAS  = 12,
  parameter int T_RP   = 8,
  parameter int T_RPS  = 22,
  parameter int T_RASS = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_cbr,
  input  logic start_sr,
  input  logic sr_exit,
  output logic ras_n,
  output logic cas_n,
  output logic idle,
  output logic done,
  output logic in_sr
);
  localparam int TMAX = max2(max2(max2(T_CSR, T_RAS), max2(T_RP, T_RPS)), T_RASS);
  localparam int CW   = $clog2(TMAX + 1);
  localparam int HW   = CW + 1;

  strobe_phase_e phase;
  logic [CW-1:0] cnt;
  logic          sr_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      sr_mode <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start_cbr || start_sr) begin
            phase   <= PH_LEAD;
            cnt     <= CW'(T_CSR - 1);
            sr_mode <= start_sr;
          end
        end
        PH_LEAD: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (sr_mode) begin
            phase <= PH_SRHOLD;
            cnt   <= CW'(T_RASS - 1);
          end else begin
            phase <= PH_RASLO;
            cnt   <= CW'(T_RAS - 1);
          end
        end
        PH_RASLO: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            phase <= PH_PRE;
            cnt   <= CW'(T_RP - 1);
          end
        end
        PH_SRHOLD: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (sr_exit) begin
            phase <= PH_PRE;
            cnt   <= CW'(T_RPS - 1);
          end
        end
        PH_PRE: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else           phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign idle  = (phase == PH_IDLE);
  assign done  = (phase == PH_PRE) && (cnt == '0);
  assign in_sr = (phase == PH_SRHOLD);
  assign cas_n = !((phase == PH_LEAD) || (phase == PH_RASLO) || (phase == PH_SRHOLD));
  assign ras_n = !((phase == PH_RASLO) || (phase == PH_SRHOLD));

  // Run-length counters observed by the timing checks below
  logic [HW-1:0] lo_cnt;
  logic [HW-1:0] hi_cnt;
  logic          after_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt   <= '0;
      hi_cnt   <= '0;
      after_sr <= 1'b0;
    end else begin
      lo_cnt <= ras_n ? '0 : ((&lo_cnt) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt <= !ras_n ? '0 : ((&hi_cnt) ? hi_cnt : hi_cnt + 1'b1);
      if (phase == PH_SRHOLD)     after_sr <= 1'b1;
      else if (phase == PH_RASLO) after_sr <= 1'b0;
    end
  end

  localparam logic [HW-1:0] MIN_LO    = HW'(T_RAS - 1);
  localparam logic [HW-1:0] MIN_HI    = HW'(T_RP - 1);
  localparam logic [HW-1:0] MIN_HI_SR = HW'(T_RPS - 1);
  localparam logic [HW-1:0] MIN_SR_LO = HW'(T_RASS - 1);

  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n))); // R4

  AST_RAS_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> ($past(lo_cnt) >= MIN_LO)); // R4

  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ($past(hi_cnt) >= MIN_HI)); // R4

  AST_SR_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && $past(in_sr)) |-> ($past(lo_cnt) >= MIN_SR_LO)); // R11

  AST_SR_EXIT_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && after_sr) |-> ($past(hi_cnt) >= MIN_HI_SR)); // R12

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import drs_pkg::*;
#(
  parameter int INIT_CYC     = 40000,
  parameter int INIT_REFS    = 8,
  parameter int REF_INTERVAL = 3100,
  parameter int PEND_MAX     = 4,
  parameter int T_CSR        = 2,
  parameter int T_RAS        = 12,
  parameter int T_RP         = 8,
  parameter int T_RPS        = 22,
  parameter int T_RASS       = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_grant,
  input  logic sr_enter_req,
  input  logic sr_exit_req,
  output logic ref_req,
  output logic ref_urgent,
  output logic bus_own,
  output logic init_done,
  output logic sr_active,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic oe_n
);
  localparam int IW = $clog2(INIT_REFS + 1);
  localparam logic [IW-1:0] INIT_LOAD = IW'(INIT_REFS);

  sched_state_e  state;
  logic [IW-1:0] init_left;
  logic          pause_tick;
  logic          ref_tick;
  logic          pend_full;
  logic          pend_empty;
  logic          seq_idle;
  logic          seq_done;
  logic          seq_in_sr;
  logic          start_cbr;
  logic          start_sr;
  logic          in_run;
  logic          in_sr_flow;

  assign in_run     = (state == ST_RUN);
  assign in_sr_flow = (state == ST_SR_PRE) || (state == ST_SR_ENTER) ||
                      (state == ST_SR_IN)  || (state == ST_SR_POST);

  drs_interval_timer #(.LIMIT(INIT_CYC)) u_pause (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (state == ST_PAUSE),
    .clr   (1'b0),
    .tick  (pause_tick)
  );

  drs_interval_timer #(.LIMIT(REF_INTERVAL)) u_ival (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (in_run),
    .clr   (!in_run),
    .tick  (ref_tick)
  );

  drs_pending_ctr #(.MAX(PEND_MAX)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (ref_tick),
    .dec   (in_run && seq_done),
    .clr   ((state == ST_SR_POST) && seq_done),
    .full  (pend_full),
    .empty (pend_empty)
  );

  assign start_cbr = ref_grant && seq_idle &&
                     (((state == ST_INIT) && (init_left != '0)) ||
                      (in_run && !pend_empty && !sr_enter_req) ||
                      (state == ST_SR_PRE) || (state == ST_SR_POST));
  assign start_sr  = ref_grant && seq_idle && (state == ST_SR_ENTER);

  drs_cbr_seq #(
    .T_CSR  (T_CSR),
    .T_RAS  (T_RAS),
    .T_RP   (T_RP),
    .T_RPS  (T_RPS),
    .T_RASS (T_RASS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_cbr (start_cbr),
    .start_sr  (start_sr),
    .sr_exit   (sr_exit_req),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .idle      (seq_idle),
    .done      (seq_done),
    .in_sr     (seq_in_sr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_PAUSE;
      init_left <= INIT_LOAD;
    end else begin
      unique case (state)
        ST_PAUSE:    if (pause_tick) state <= ST_INIT;
        ST_INIT: begin
          if (seq_done) begin
            init_left <= init_left - 1'b1;
            if (init_left == IW'(1)) state <= ST_RUN;
          end
        end
        ST_RUN:      if (sr_enter_req && seq_idle) state <= ST_SR_PRE;
        ST_SR_PRE:   if (seq_done) state <= ST_SR_ENTER;
        ST_SR_ENTER: if (start_sr) state <= ST_SR_IN;
        ST_SR_IN:    if (seq_done) state <= ST_SR_POST;
        ST_SR_POST:  if (seq_done) state <= ST_RUN;
        default:     state <= ST_PAUSE;
      endcase
    end
  end

  assign ref_req    = ((state == ST_INIT) && (init_left != '0)) ||
                      (in_run && !pend_empty) || in_sr_flow;
  assign ref_urgent = in_run && pend_full;
  assign bus_own    = !seq_idle;
  assign init_done  = (state != ST_PAUSE) && (state != ST_INIT);
  assign sr_active  = seq_in_sr;
  assign we_n       = 1'b1;
  assign oe_n       = 1'b1;

  // Completed refreshes during power-up, seen by the init check
  logic [IW-1:0] init_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             init_seen <= '0;
    else if ((state == ST_INIT) && seq_done) init_seen <= init_seen + 1'b1;
  end

  AST_QUIET_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PAUSE) |-> (ras_n && cas_n && !ref_req)); // R2

  AST_INIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (init_seen == INIT_LOAD)); // R3

  AST_START_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(ref_grant)); // R9

  AST_URGENT_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> ref_req); // R8

  AST_SR_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> (ref_req && bus_own && !ras_n)); // R10

endmodule

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
  localparam int INIT_CYC = 200;
  localparam int INIT_REFS = 8;
  localparam int P = 400;
  localparam int PMAX = 4;
  localparam int T_CSR = 2;
  localparam int T_RAS = 6;
  localparam int T_RP = 4;
  localparam int T_RPS = 9;
  localparam int T_RASS = 50;
  localparam int SPACING = T_CSR + T_RAS + T_RP + 1;
  localparam int WD_LIMIT = 60000;

  // Vectors: intervals withheld, expected burst, expected urgency
  localparam int NV = 5;
  localparam int VEC_HOLD  [NV] = '{1, 2, 4, 5, 7};
  localparam int VEC_BURST [NV] = '{1, 2, 4, 4, 4};
  localparam int VEC_URG   [NV] = '{0, 0, 1, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_grant = 1'b0;
  logic sr_enter_req = 1'b0;
  logic sr_exit_req = 1'b0;
  logic ref_req, ref_urgent, bus_own, init_done, sr_active;
  logic ras_n, cas_n, we_n, oe_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2500 clk = ~clk;  // 5 ns period with a 1 ps time unit

  dram_refresh_sched #(
    .INIT_CYC(INIT_CYC), .INIT_REFS(INIT_REFS), .REF_INTERVAL(P),
    .PEND_MAX(PMAX), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_RPS(T_RPS), .T_RASS(T_RASS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant),
    .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .bus_own(bus_own),
    .init_done(init_done), .sr_active(sr_active),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  // Strobe monitor sampling at the falling clock edge
  bit mon_en = 1'b0;
  bit prev_ras = 1'b1;
  int fall_cnt = 0, last_fall = 0, fall_gap = 0;
  int lo_run = 0, hi_run = 0, cas_run = 0;
  int last_low_w = 0, last_high_w = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (prev_ras && !ras_n) begin
        fall_cnt++;
        fall_gap = cyc - last_fall;
        last_fall = cyc;
        last_high_w = hi_run;
        check_eq("R4 cas lead before ras fall", cas_run, T_CSR);
        check_eq("R4 cas low at ras fall", int'(cas_n), 0);
        check_eq("R5 we_n/oe_n high at ras fall", int'(we_n && oe_n), 1);
        check_eq("R9 bus_own during strobes", int'(bus_own), 1);
        lo_run = 1;
        hi_run = 0;
      end else if (!prev_ras && ras_n) begin
        last_low_w = lo_run;
        lo_run = 0;
        hi_run = 1;
        cas_run = cas_n ? 0 : 1;
      end else if (ras_n) begin
        hi_run++;
        cas_run = cas_n ? 0 : cas_run + 1;
      end else begin
        lo_run++;
      end
      prev_ras = ras_n;
    end
  end

  task automatic step();
    @(negedge clk);
    #500;
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    int t_rel, t_req, t1, t2, t3, f0;

    // R1: reset state
    steps(3);
    check_eq("R1 ras_n in reset", int'(ras_n), 1);
    check_eq("R1 cas_n in reset", int'(cas_n), 1);
    check_eq("R1 we_n/oe_n in reset", int'(we_n && oe_n), 1);
    check_eq("R1 ref_req in reset", int'(ref_req), 0);
    check_eq("R1 ref_urgent in reset", int'(ref_urgent), 0);
    check_eq("R1 bus_own in reset", int'(bus_own), 0);
    check_eq("R1 init_done in reset", int'(init_done), 0);
    check_eq("R1 sr_active in reset", int'(sr_active), 0);

    // R2/R3: power-up pause with grant already offered
    ref_grant = 1'b1;
    rst_n = 1'b1;
    mon_en = 1'b1;
    t_rel = cyc;
    while (!ref_req) step();
    t_req = cyc;
    check_eq("R2 no request during pause", int'((t_req - t_rel) >= INIT_CYC), 1);
    check_eq("R2 no strobe during pause", fall_cnt, 0);
    while (!init_done) step();
    check_eq("R3 power-up refresh count", fall_cnt, INIT_REFS);
    check_eq("R4 ras low width", last_low_w, T_RAS);
    check_eq("R4 back-to-back spacing in init", fall_gap, SPACING);
    check_eq("R9 request drops after init", int'(ref_req), 0);

    // R6: periodic refresh with grant held
    f0 = fall_cnt;
    while (fall_cnt == f0) step();
    t1 = last_fall;
    while (fall_cnt == f0 + 1) step();
    t2 = last_fall;
    while (fall_cnt == f0 + 2) step();
    t3 = last_fall;
    check_eq("R6 interval first", t2 - t1, P);
    check_eq("R6 interval second", t3 - t2, P);
    check_eq("R3 init_done stays high", int'(init_done), 1);
    while (ref_req || bus_own) step();
    ref_grant = 1'b0;

    // R7/R8/R9: table of withheld-grant vectors
    for (int i = 0; i < NV; i++) begin
      while (!ref_req) step();
      f0 = fall_cnt;
      steps((VEC_HOLD[i] - 1) * P + P / 2);
      check_eq("R9 no strobe without grant", fall_cnt - f0, 0);
      check_eq("R9 request held while owed", int'(ref_req), 1);
      check_eq("R8 urgency at limit", int'(ref_urgent), VEC_URG[i]);
      ref_grant = 1'b1;
      while (ref_req) step();
      ref_grant = 1'b0;
      check_eq("R7 burst size", fall_cnt - f0, VEC_BURST[i]);
      if (VEC_BURST[i] > 1) check_eq("R7 burst spacing", fall_gap, SPACING);
      check_eq("R8 urgency clears after burst", int'(ref_urgent), 0);
    end

    // R10/R11/R12: self refresh with a full owed count
    while (!ref_urgent) step();
    f0 = fall_cnt;
    ref_grant = 1'b1;
    sr_enter_req = 1'b1;
    while (!sr_active) step();
    sr_enter_req = 1'b0;
    sr_exit_req = 1'b1;  // early exit request must not shorten the hold
    check_eq("R10 one refresh then hold", fall_cnt - f0, 2);
    check_eq("R10 entry refresh width", last_low_w, T_RAS);
    check_eq("R10 gap before hold", last_high_w, T_RP + 1 + T_CSR);
    check_eq("R10 request held in self refresh", int'(ref_req && bus_own), 1);
    check_eq("R10 strobes low in self refresh", int'(ras_n || cas_n), 0);
    while (sr_active) step();
    sr_exit_req = 1'b0;
    check_eq("R11 self refresh hold width", last_low_w, T_RASS);
    while (fall_cnt == f0 + 2) step();
    check_eq("R12 exit precharge", last_high_w, T_RPS + 1 + T_CSR);
    while (ref_req) step();
    check_eq("R12 exactly one refresh after exit", fall_cnt - f0, 3);
    check_eq("R12 exit refresh width", last_low_w, T_RAS);
    check_eq("R12 sr_active low after exit", int'(sr_active), 0);
    ref_grant = 1'b0;
    steps(P / 2);
    check_eq("R12 owed count cleared", int'(ref_req), 0);
    check_eq("R12 no urgency after exit", int'(ref_urgent), 0);
    check_eq("R12 no extra strobes", fall_cnt - f0, 3);

    finish_run();
  end

endmodule